// File: doc/BRIEF.md
# Programmable interval timer with event outputs

The block is an 8-bit down-counting interval timer clocked from the system clock through an internal divider. The divider produces one tick every 0.1 ms; the default is 5000 clocks at 50 MHz. The counter starts from a programmable reload value and counts down one step per tick. When its interval runs out it reloads and records a sticky event flag. That flag can drive a level interrupt and a stretched event output. Each expiry can also fire a short fixed-length pulse on a second output.

Software sets the reload value and four control bits, and can read back the reload value, the live count, the control bits and the event flag. It acknowledges an event by pulsing the clear input. While the run bit is low, the counter is pinned to the reload value. This makes the first interval after enabling exactly the programmed length.

Top module: `ivt_timer`

## Requirements
- R1: With the run bit set and a reload value L in 1..255, the first expiry occurs L*TICK_DIV clocks after the edge that set the run bit, and further expiries follow every L*TICK_DIV clocks.
- R2: After reset, latch_o reads 8'hFF, count_o reads 8'hFF, ctrl_o reads 0, and occur_o, irq_o, occ_pulse_o and tc_pulse_o are low.
- R3: While the run bit is clear, count_o equals the reload value one clock after any change, the tick divider restarts, and no expiry occurs.
- R4: count_o shows the live count. It drops by one on each tick and returns to the reload value on the tick of expiry.
- R5: occur_o rises on the clock of an expiry and stays high until a clock in which occ_clr_i is high.
- R6: irq_o is a level that is high exactly while occur_o is high and control bit 1 is set.
- R7: occ_pulse_o is high exactly while occur_o is high and control bit 2 is set.
- R8: With control bit 3 set, tc_pulse_o goes high on the clock of each expiry for PULSE_CYC clocks, then falls.
- R9: A reload value of 0 gives an interval of 256 ticks, and the count reads 255 after the first tick.
- R10: If an expiry and occ_clr_i fall on the same clock, occur_o is left set.
- R11: A reload value written while running does not change the interval in progress; it applies from the next reload.
- R12: A control write (ctrl_we_i) stores ctrl_wdata_i with bit 0 = run, bit 1 = interrupt enable, bit 2 = event-output enable and bit 3 = terminal-pulse enable, and ctrl_o reads the bits back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| latch_we_i | input | 1 | Write strobe for the reload value |
| latch_wdata_i | input | 8 | New reload value |
| ctrl_we_i | input | 1 | Write strobe for the control bits |
| ctrl_wdata_i | input | 4 | New control bits (run, irq enable, event out enable, pulse enable) |
| occ_clr_i | input | 1 | Clear of the event flag, active high |
| latch_o | output | 8 | Reload value readback |
| count_o | output | 8 | Live counter value |
| ctrl_o | output | 4 | Control bits readback |
| occur_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Level interrupt request |
| occ_pulse_o | output | 1 | Event output, held until the flag is cleared |
| tc_pulse_o | output | 1 | Fixed-length pulse at each expiry |

## Verification
The two functions that can meet in one cycle are an expiry setting the event flag and software clearing it. The bench uses a reload of one tick so that expiries come at known clock numbers. It holds the clear input across the clock of an expiry and requires the flag to survive that clock. It then requires the flag to drop on the following clock, when the clear is still high and no expiry is due.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // bit 0 run, bit 1 irq enable, bit 2 event output enable, bit 3 pulse enable
  typedef struct packed {
    logic tc_oe;
    logic occ_oe;
    logic irq_en;
    logic run;
  } ivt_ctrl_t;

  localparam int unsigned CTRL_W = $bits(ivt_ctrl_t);
endpackage

// File: rtl/ivt_prescale.sv
module ivt_prescale #(
  parameter int unsigned DIV = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] div_q;

      assign tick_o = run_i && (div_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          div_q <= '0;
        else if (!run_i)      div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                  div_q <= div_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/ivt_downcnt.sv
module ivt_downcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] count_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  // a reload of zero wraps through all ones, giving 2**W ticks
  assign expire_o = run_i && tick_i && (cnt_q == ONE);
  assign count_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '1;
    else if (!run_i)   cnt_q <= reload_i;
    else if (expire_o) cnt_q <= reload_i;
    else if (tick_i)   cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/ivt_pulse.sv
module ivt_pulse #(
  parameter int unsigned LEN = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned LW = $clog2(LEN + 1);
  logic [LW-1:0] left_q;

  assign pulse_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      left_q <= '0;
    else if (trig_i)  left_q <= LW'(LEN);
    else if (pulse_o) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned TICK_DIV  = 5000,
  parameter int unsigned PULSE_CYC = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_we_i,
  input  logic [CNT_W-1:0] latch_wdata_i,
  input  logic             ctrl_we_i,
  input  logic [3:0]       ctrl_wdata_i,
  input  logic             occ_clr_i,
  output logic [CNT_W-1:0] latch_o,
  output logic [CNT_W-1:0] count_o,
  output logic [3:0]       ctrl_o,
  output logic             occur_o,
  output logic             irq_o,
  output logic             occ_pulse_o,
  output logic             tc_pulse_o
);
  ivt_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] latch_q;
  logic             occur_q;
  logic             tick;
  logic             expire;
  logic             tc_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '1;
      ctrl_q  <= '0;
    end else begin
      if (latch_we_i) latch_q <= latch_wdata_i;
      if (ctrl_we_i)  ctrl_q  <= ivt_ctrl_t'(ctrl_wdata_i);
    end
  end

  ivt_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.run),
    .tick_o (tick)
  );

  ivt_downcnt #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl_q.run),
    .tick_i   (tick),
    .reload_i (latch_q),
    .count_o  (count_o),
    .expire_o (expire)
  );

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        occur_q <= 1'b0;
    else if (expire)    occur_q <= 1'b1;
    else if (occ_clr_i) occur_q <= 1'b0;
  end

  ivt_pulse #(.LEN(PULSE_CYC)) u_tc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (expire),
    .pulse_o (tc_raw)
  );

  assign latch_o     = latch_q;
  assign ctrl_o      = ctrl_q;
  assign occur_o     = occur_q;
  assign irq_o       = occur_q & ctrl_q.irq_en;
  assign occ_pulse_o = occur_q & ctrl_q.occ_oe;
  assign tc_pulse_o  = tc_raw & ctrl_q.tc_oe;
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             occ_clr_i,
  input logic [CNT_W-1:0] latch_o,
  input logic [CNT_W-1:0] count_o,
  input logic [3:0]       ctrl_o,
  input logic             occur_o,
  input logic             irq_o,
  input logic             occ_pulse_o,
  input logic             tc_pulse_o
);
  a_r3_pinned_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[0] |=> count_o == $past(latch_o));

  a_r4_step_or_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[0] && $past(ctrl_o[0]) && !$stable(count_o)) |->
      (count_o == CNT_W'($past(count_o) - 1'b1)) || (count_o == $past(latch_o)));

  a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occur_o && !occ_clr_i) |=> occur_o);

  a_r6_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> occur_o);

  a_r7_out_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_pulse_o |-> occur_o);

  a_r8_pulse_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_pulse_o |-> ctrl_o[3]);

  a_r10_pulse_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tc_pulse_o) && $stable(ctrl_o)) |-> occur_o);
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .occ_clr_i   (occ_clr_i),
  .latch_o     (latch_o),
  .count_o     (count_o),
  .ctrl_o      (ctrl_o),
  .occur_o     (occur_o),
  .irq_o       (irq_o),
  .occ_pulse_o (occ_pulse_o),
  .tc_pulse_o  (tc_pulse_o)
);

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
  localparam int unsigned DIV = 4;
  localparam int unsigned PLEN = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       latch_we_i = 1'b0;
  logic [7:0] latch_wdata_i = '0;
  logic       ctrl_we_i = 1'b0;
  logic [3:0] ctrl_wdata_i = '0;
  logic       occ_clr_i = 1'b0;
  logic [7:0] latch_o, count_o;
  logic [3:0] ctrl_o;
  logic       occur_o, irq_o, occ_pulse_o, tc_pulse_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_q = 0;
  int exp_q[$];
  logic tc_prev = 1'b0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc_q <= cyc_q + 1;

  ivt_timer #(.CNT_W(8), .TICK_DIV(DIV), .PULSE_CYC(PLEN)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: each rising terminal pulse must match the next expected clock
  always @(negedge clk_i) begin
    if (tc_pulse_o && !tc_prev) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected expiry at clock", cyc_q, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc_q == e, "R1 expiry clock", cyc_q, e);
      end
    end
    tc_prev <= tc_pulse_o;
  end

  task automatic wait_to(input int n);
    while (cyc_q < n) @(negedge clk_i);
  endtask

  task automatic wr_ctrl(input logic [3:0] v, output int edge_n);
    ctrl_wdata_i = v;
    ctrl_we_i = 1'b1;
    edge_n = cyc_q + 1;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic wr_latch(input logic [7:0] v);
    latch_wdata_i = v;
    latch_we_i = 1'b1;
    @(negedge clk_i);
    latch_we_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc_q, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2 reset state
    chk(latch_o == 8'hFF, "R2 latch", latch_o, 255);
    chk(count_o == 8'hFF, "R2 count", count_o, 255);
    chk(ctrl_o == 4'h0, "R2 ctrl", ctrl_o, 0);
    chk({occur_o, irq_o, occ_pulse_o, tc_pulse_o} == 4'b0, "R2 outputs",
        {occur_o, irq_o, occ_pulse_o, tc_pulse_o}, 0);

    // R3 counter follows latch while stopped
    wr_latch(8'd5);
    @(negedge clk_i);
    chk(count_o == 8'd5, "R3 count follows latch", count_o, 5);

    // R1/R4/R5 reload 3, terminal pulse enabled only
    wr_latch(8'd3);
    @(negedge clk_i);
    wr_ctrl(4'b1001, e);
    chk(ctrl_o == 4'b1001, "R12 ctrl readback", ctrl_o, 9);
    exp_q.push_back(e + 12); exp_q.push_back(e + 24); exp_q.push_back(e + 36);
    exp_q.push_back(e + 48);
    wait_to(e + 4);
    chk(count_o == 8'd2, "R4 count after one tick", count_o, 2);
    wait_to(e + 11);
    chk(occur_o == 1'b0, "R5 flag before expiry", occur_o, 0);
    wait_to(e + 12);
    chk(occur_o == 1'b1, "R5 flag at expiry", occur_o, 1);
    chk(count_o == 8'd3, "R4 reload at expiry", count_o, 3);
    chk(irq_o == 1'b0, "R6 irq masked", irq_o, 0);
    chk(occ_pulse_o == 1'b0, "R7 event output disabled", occ_pulse_o, 0);
    wait_to(e + 53);
    chk(count_o == 8'd2, "R4 mid interval", count_o, 2);
    wr_ctrl(4'b0000, e);
    @(negedge clk_i);
    chk(count_o == 8'd3, "R3 stop pins count to latch", count_o, 3);
    repeat (30) @(negedge clk_i);
    chk(count_o == 8'd3, "R3 no counting while stopped", count_o, 3);
    chk(occur_o == 1'b1, "R5 flag sticky", occur_o, 1);

    // R6/R7 enables on a held flag, then clear
    wr_ctrl(4'b0110, e);
    chk(irq_o == 1'b1, "R6 irq level", irq_o, 1);
    chk(occ_pulse_o == 1'b1, "R7 event output", occ_pulse_o, 1);
    occ_clr_i = 1'b1;
    @(negedge clk_i);
    occ_clr_i = 1'b0;
    chk(occur_o == 1'b0, "R5 flag cleared", occur_o, 0);
    chk(irq_o == 1'b0, "R6 irq drops on clear", irq_o, 0);
    chk(occ_pulse_o == 1'b0, "R7 event output drops", occ_pulse_o, 0);

    // R8/R10 reload 1: expiry every tick
    wr_latch(8'd1);
    @(negedge clk_i);
    wr_ctrl(4'b1001, e);
    exp_q.push_back(e + 4); exp_q.push_back(e + 8);
    exp_q.push_back(e + 12); exp_q.push_back(e + 16);
    wait_to(e + 4);
    chk(tc_pulse_o == 1'b1, "R8 pulse clock 1", tc_pulse_o, 1);
    wait_to(e + 6);
    chk(tc_pulse_o == 1'b1, "R8 pulse clock 3", tc_pulse_o, 1);
    wait_to(e + 7);
    chk(tc_pulse_o == 1'b0, "R8 pulse ends", tc_pulse_o, 0);
    wait_to(e + 15);
    occ_clr_i = 1'b1;
    @(negedge clk_i);
    chk(occur_o == 1'b1, "R10 set wins over clear", occur_o, 1);
    @(negedge clk_i);
    chk(occur_o == 1'b0, "R5 clear after collision", occur_o, 0);
    occ_clr_i = 1'b0;
    wr_ctrl(4'b0000, e);

    // R9/R11 reload 0 = 256 ticks, latch change mid interval
    wr_latch(8'd0);
    @(negedge clk_i);
    chk(count_o == 8'd0, "R9 zero reload shown", count_o, 0);
    wr_ctrl(4'b1001, e);
    exp_q.push_back(e + 1024);
    wait_to(e + 4);
    chk(count_o == 8'd255, "R9 wrap after first tick", count_o, 255);
    wait_to(e + 1023);
    chk(occur_o == 1'b0, "R9 no early expiry", occur_o, 0);
    wait_to(e + 1024);
    chk(occur_o == 1'b1, "R9 expiry after 256 ticks", occur_o, 1);
    wait_to(e + 1030);
    wr_latch(8'd2);
    exp_q.push_back(e + 2048); exp_q.push_back(e + 2056);
    wait_to(e + 1100);
    chk(count_o == 8'd237, "R11 interval unchanged", count_o, 237);
    wait_to(e + 2048);
    chk(count_o == 8'd2, "R11 new value at reload", count_o, 2);
    wait_to(e + 2060);
    wr_ctrl(4'b0000, e);
    repeat (10) @(negedge clk_i);
    chk(exp_q.size() == 0, "R1 all expiries seen", exp_q.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule